// File: doc/BRIEF.md
# Ethernet PHY Bring-Up Sequencer

This controller takes an Ethernet transceiver from power-on to a known state. On a start request it pulses the transceiver's active-low hardware reset for a programmed time. It then looks for the first management address that answers with its control-register reset bit clear, and checks the link status bit. If the link is down, it soft-resets the transceiver, waits for the reset bit to self-clear, and starts auto-negotiation. It then polls for link with a fixed spacing and a bounded number of attempts.

All register traffic goes through a simple request/response port to a separate management-bus serialiser, with at most one transaction in flight. Every delay is a parameter counted in system clock cycles. The outcome is a one-cycle done pulse together with the discovered address and exactly one of four result flags. The address and flags stay valid until the next start.

Top module: `phy_bringup`

## Requirements
- R1: After reset `phy_rst_n` is 1. An accepted `start` drives it to 0 for exactly RST_HOLD_CYC clock cycles, and no management request is issued while it is 0.
- R2: Register 0 (control) is read at addresses 0, 1, 2, … in increasing order. The first address whose read data has bit 15 equal to 0 is chosen and reported on `phy_addr`. All later requests of that run go to that address.
- R3: If all 32 addresses return bit 15 set, `err_no_phy` is raised with `phy_addr` = 0 and the run ends without further requests.
- R4: After the address is found, register 1 (status) is read. If its bit 2 (link) is 1, the run ends with `link_up` = 1 and no write is issued.
- R5: With the link down, the value 0x8000 is written to register 0. Register 0 is then read up to SRST_TRIES times until bit 15 reads 0. Every write targets register 0.
- R6: If bit 15 is still 1 on all SRST_TRIES reads, `err_soft_rst` is raised and the run ends.
- R7: Once bit 15 clears, 0x1300 is written to register 0 (bits 12, 9 and 8 set), and register 1 is polled. A poll returning bit 2 = 1 ends the run with `link_up` = 1.
- R8: After a poll that returns no link, and while polls remain, the next status read request is raised POLL_GAP_CYC+1 cycles after the cycle in which `mdio_done` was high.
- R9: If POLL_MAX polls all return no link, `warn_link_timeout` is raised and `link_up` stays 0.
- R10: `mdio_req` is a one-cycle pulse. No new request is raised before `mdio_done` answers the previous one. `mdio_we`, `mdio_phy`, `mdio_reg` and `mdio_wdata` stay stable while a request is outstanding.
- R11: At the end of a run, `done` pulses for one cycle and exactly one of `link_up`, `err_no_phy`, `err_soft_rst`, `warn_link_timeout` is 1. The flags hold until the next accepted start, which clears them. A `start` during a run is ignored.
- R12: After reset, `mdio_req`, `done`, `phy_addr` and all four result flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up run (accepted when idle) |
| phy_rst_n | output | 1 | Active-low hardware reset to the transceiver |
| mdio_req | output | 1 | One-cycle request strobe to the management master |
| mdio_we | output | 1 | 1 = register write, 0 = register read |
| mdio_phy | output | 5 | Transceiver address of the request |
| mdio_reg | output | 5 | Register number of the request |
| mdio_wdata | output | 16 | Write data |
| mdio_done | input | 1 | One-cycle completion of the outstanding request |
| mdio_rdata | input | 16 | Read data, valid with mdio_done |
| done | output | 1 | One-cycle end-of-run pulse |
| phy_addr | output | 5 | Discovered transceiver address |
| link_up | output | 1 | Link established |
| err_no_phy | output | 1 | No address answered during the scan |
| err_soft_rst | output | 1 | Soft reset did not self-clear |
| warn_link_timeout | output | 1 | Link polling budget exhausted |

## Verification
The reset output falls in the cycle after `start` is sampled and must read low on exactly RST_HOLD_CYC consecutive falling-edge samples. After a missed poll, the next request must appear exactly POLL_GAP_CYC+1 sampled cycles after the cycle that carried `mdio_done`. The bench model answers every request three cycles later, so the result flags are checked on the same falling edge on which `done` is first seen, and again four cycles later to confirm they hold. Request counts, write values and per-request addresses are collected by the model as the run progresses. They are compared against hand-computed totals for each scenario, so no check depends on the model's latency beyond the gap rule.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;
  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int DW     = 16;
  localparam int NUM_ADDR = 1 << PHY_AW;

  localparam logic [REG_AW-1:0] REG_CTRL = 5'd0;
  localparam logic [REG_AW-1:0] REG_STAT = 5'd1;

  localparam int BIT_RESET  = 15;
  localparam int BIT_ANEG   = 12;
  localparam int BIT_RESTRT = 9;
  localparam int BIT_FDX    = 8;
  localparam int BIT_LINK   = 2;

  typedef enum logic [2:0] {ST_IDLE, ST_HOLD, ST_ISSUE, ST_WAIT, ST_GAP} state_e;
  typedef enum logic [2:0] {PH_SCAN, PH_LINK, PH_SRST, PH_SRCHK, PH_ANEG, PH_POLL} phase_e;

  function automatic logic [DW-1:0] soft_reset_word();
    logic [DW-1:0] w;
    w = '0;
    w[BIT_RESET] = 1'b1;
    return w;
  endfunction

  function automatic logic [DW-1:0] aneg_word();
    logic [DW-1:0] w;
    w = '0;
    w[BIT_ANEG]   = 1'b1;
    w[BIT_RESTRT] = 1'b1;
    w[BIT_FDX]    = 1'b1;
    return w;
  endfunction

  function automatic logic ctrl_in_reset(input logic [DW-1:0] d);
    return d[BIT_RESET];
  endfunction

  function automatic logic stat_has_link(input logic [DW-1:0] d);
    return d[BIT_LINK];
  endfunction
endpackage

// File: rtl/phy_bringup_timer.sv
module phy_bringup_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/phy_bringup_mdio_if.sv
module phy_bringup_mdio_if
  import phy_bringup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_we,
  input  logic [PHY_AW-1:0] go_phy,
  input  logic [REG_AW-1:0] go_reg,
  input  logic [DW-1:0]     go_wdata,
  output logic              mdio_req,
  output logic              mdio_we,
  output logic [PHY_AW-1:0] mdio_phy,
  output logic [REG_AW-1:0] mdio_reg,
  output logic [DW-1:0]     mdio_wdata,
  input  logic              mdio_done,
  input  logic [DW-1:0]     mdio_rdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data
);
  logic busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdio_req   <= 1'b0;
      mdio_we    <= 1'b0;
      mdio_phy   <= '0;
      mdio_reg   <= '0;
      mdio_wdata <= '0;
      busy       <= 1'b0;
    end else begin
      mdio_req <= 1'b0;
      if (go && !busy) begin
        mdio_req   <= 1'b1;
        mdio_we    <= go_we;
        mdio_phy   <= go_phy;
        mdio_reg   <= go_reg;
        mdio_wdata <= go_wdata;
        busy       <= 1'b1;
      end else if (mdio_done) begin
        busy <= 1'b0;
      end
    end
  end

  assign rsp_valid = busy && mdio_done;
  assign rsp_data  = mdio_rdata;
endmodule

// File: rtl/phy_bringup.sv
module phy_bringup
  import phy_bringup_pkg::*;
#(
  parameter int RST_HOLD_CYC = 750000,
  parameter int POLL_GAP_CYC = 500000,
  parameter int POLL_MAX     = 500,
  parameter int SRST_TRIES   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              phy_rst_n,
  output logic              mdio_req,
  output logic              mdio_we,
  output logic [PHY_AW-1:0] mdio_phy,
  output logic [REG_AW-1:0] mdio_reg,
  output logic [DW-1:0]     mdio_wdata,
  input  logic              mdio_done,
  input  logic [DW-1:0]     mdio_rdata,
  output logic              done,
  output logic [PHY_AW-1:0] phy_addr,
  output logic              link_up,
  output logic              err_no_phy,
  output logic              err_soft_rst,
  output logic              warn_link_timeout
);
  localparam int TMAX = (RST_HOLD_CYC > POLL_GAP_CYC) ? RST_HOLD_CYC : POLL_GAP_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(POLL_MAX + 1);
  localparam int SW   = $clog2(SRST_TRIES + 1);
  localparam logic [PHY_AW-1:0] LAST_ADDR = PHY_AW'(NUM_ADDR - 1);

  state_e state;
  phase_e phase;
  logic [PHY_AW-1:0] scan_addr;
  logic [PW-1:0]     poll_cnt;
  logic [SW-1:0]     try_cnt;

  logic              go, go_we;
  logic [PHY_AW-1:0] go_phy;
  logic [REG_AW-1:0] go_reg;
  logic [DW-1:0]     go_wdata;
  logic              rsp_valid;
  logic [DW-1:0]     rsp_data;

  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;

  // named internal events
  logic ev_start, ev_rsp, ev_poll_retry, ev_hold_end;

  assign ev_start      = start && (state == ST_IDLE);
  assign ev_rsp        = rsp_valid && (state == ST_WAIT);
  assign ev_hold_end   = (state == ST_HOLD) && tmr_zero;
  assign ev_poll_retry = ev_rsp && (phase == PH_POLL) && !stat_has_link(rsp_data)
                         && (poll_cnt != PW'(POLL_MAX - 1));

  assign tmr_load = ev_start || ev_poll_retry;
  assign tmr_val  = ev_start ? TW'(RST_HOLD_CYC - 1) : TW'(POLL_GAP_CYC - 1);

  phy_bringup_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  always_comb begin
    go       = (state == ST_ISSUE);
    go_we    = 1'b0;
    go_phy   = phy_addr;
    go_reg   = REG_CTRL;
    go_wdata = '0;
    case (phase)
      PH_SCAN:  go_phy = scan_addr;
      PH_LINK:  go_reg = REG_STAT;
      PH_SRST:  begin go_we = 1'b1; go_wdata = soft_reset_word(); end
      PH_SRCHK: go_reg = REG_CTRL;
      PH_ANEG:  begin go_we = 1'b1; go_wdata = aneg_word(); end
      PH_POLL:  go_reg = REG_STAT;
      default:  go_reg = REG_CTRL;
    endcase
  end

  phy_bringup_mdio_if u_mif (
    .clk(clk), .rst_n(rst_n),
    .go(go), .go_we(go_we), .go_phy(go_phy), .go_reg(go_reg), .go_wdata(go_wdata),
    .mdio_req(mdio_req), .mdio_we(mdio_we), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_wdata(mdio_wdata), .mdio_done(mdio_done), .mdio_rdata(mdio_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state             <= ST_IDLE;
      phase             <= PH_SCAN;
      scan_addr         <= '0;
      poll_cnt          <= '0;
      try_cnt           <= '0;
      phy_rst_n         <= 1'b1;
      done              <= 1'b0;
      phy_addr          <= '0;
      link_up           <= 1'b0;
      err_no_phy        <= 1'b0;
      err_soft_rst      <= 1'b0;
      warn_link_timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (ev_start) begin
          state             <= ST_HOLD;
          phy_rst_n         <= 1'b0;
          phase             <= PH_SCAN;
          scan_addr         <= '0;
          phy_addr          <= '0;
          link_up           <= 1'b0;
          err_no_phy        <= 1'b0;
          err_soft_rst      <= 1'b0;
          warn_link_timeout <= 1'b0;
        end
        ST_HOLD: if (ev_hold_end) begin
          phy_rst_n <= 1'b1;
          state     <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_GAP:   if (tmr_zero) state <= ST_ISSUE;
        ST_WAIT: if (ev_rsp) begin
          state <= ST_ISSUE;
          case (phase)
            PH_SCAN: begin
              if (!ctrl_in_reset(rsp_data)) begin
                phy_addr <= scan_addr;
                phase    <= PH_LINK;
              end else if (scan_addr == LAST_ADDR) begin
                err_no_phy <= 1'b1;
                done       <= 1'b1;
                state      <= ST_IDLE;
              end else begin
                scan_addr <= scan_addr + 1'b1;
              end
            end
            PH_LINK: begin
              if (stat_has_link(rsp_data)) begin
                link_up <= 1'b1;
                done    <= 1'b1;
                state   <= ST_IDLE;
              end else begin
                phase <= PH_SRST;
              end
            end
            PH_SRST: begin
              phase   <= PH_SRCHK;
              try_cnt <= '0;
            end
            PH_SRCHK: begin
              if (!ctrl_in_reset(rsp_data)) begin
                phase <= PH_ANEG;
              end else if (try_cnt == SW'(SRST_TRIES - 1)) begin
                err_soft_rst <= 1'b1;
                done         <= 1'b1;
                state        <= ST_IDLE;
              end else begin
                try_cnt <= try_cnt + 1'b1;
              end
            end
            PH_ANEG: begin
              phase    <= PH_POLL;
              poll_cnt <= '0;
            end
            default: begin
              if (stat_has_link(rsp_data)) begin
                link_up <= 1'b1;
                done    <= 1'b1;
                state   <= ST_IDLE;
              end else if (ev_poll_retry) begin
                poll_cnt <= poll_cnt + 1'b1;
                state    <= ST_GAP;
              end else begin
                warn_link_timeout <= 1'b1;
                done              <= 1'b1;
                state             <= ST_IDLE;
              end
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_bringup_chk.sv
module phy_bringup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        phy_rst_n,
  input logic        mdio_req,
  input logic        mdio_we,
  input logic [4:0]  mdio_phy,
  input logic [4:0]  mdio_reg,
  input logic [15:0] mdio_wdata,
  input logic        mdio_done,
  input logic        done,
  input logic        link_up,
  input logic        err_no_phy,
  input logic        err_soft_rst,
  input logic        warn_link_timeout,
  input logic        ev_start
);
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_q <= 1'b0;
    else if (mdio_req)  out_q <= 1'b1;
    else if (mdio_done) out_q <= 1'b0;
  end

  assert_rst_from_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_rst_n) |-> $past(start));

  assert_quiet_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_rst_n |-> !mdio_req);

  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |-> !out_q);

  assert_fields_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> ($stable(mdio_phy) && $stable(mdio_reg) && $stable(mdio_we) && $stable(mdio_wdata)));

  assert_write_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_we) |-> (mdio_reg == 5'd0 && (mdio_wdata == 16'h8000 || mdio_wdata == 16'h1300)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({link_up, err_no_phy, err_soft_rst, warn_link_timeout}) == 1));

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ev_start) && !done) |-> $stable({link_up, err_no_phy, err_soft_rst, warn_link_timeout}));
endmodule

bind phy_bringup phy_bringup_chk u_chk (.*);

// File: tb/sim_phy_bringup.sv
module sim_phy_bringup;
  localparam int H   = 20;
  localparam int G   = 6;
  localparam int PM  = 5;
  localparam int ST  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic phy_rst_n, mdio_req, mdio_we, done, link_up, err_no_phy, err_soft_rst, warn_link_timeout;
  logic [4:0] mdio_phy, mdio_reg, phy_addr;
  logic [15:0] mdio_wdata;
  logic mdio_done = 1'b0;
  logic [15:0] mdio_rdata = 16'h0;

  always #10 clk = ~clk;

  phy_bringup #(.RST_HOLD_CYC(H), .POLL_GAP_CYC(G), .POLL_MAX(PM), .SRST_TRIES(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .phy_rst_n(phy_rst_n),
    .mdio_req(mdio_req), .mdio_we(mdio_we), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_wdata(mdio_wdata), .mdio_done(mdio_done), .mdio_rdata(mdio_rdata),
    .done(done), .phy_addr(phy_addr), .link_up(link_up), .err_no_phy(err_no_phy),
    .err_soft_rst(err_soft_rst), .warn_link_timeout(warn_link_timeout)
  );

  // result codes: 0 link up, 1 no phy, 2 soft reset failed, 3 link timeout
  typedef struct packed {
    logic [7:0] first; logic [7:0] link0; logic [7:0] srst; logic [7:0] polls;
    logic [7:0] eaddr; logic [7:0] eres;  logic [7:0] enreq; logic [7:0] enwr;
    logic [7:0] egaps;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{8'd0,  8'd1, 8'd0,  8'd0, 8'd0,  8'd0, 8'd2,  8'd0, 8'd0},
    '{8'd5,  8'd1, 8'd0,  8'd0, 8'd5,  8'd0, 8'd7,  8'd0, 8'd0},
    '{8'd31, 8'd0, 8'd3,  8'd2, 8'd31, 8'd0, 8'd42, 8'd2, 8'd2},
    '{8'd32, 8'd0, 8'd0,  8'd0, 8'd0,  8'd1, 8'd32, 8'd0, 8'd0},
    '{8'd2,  8'd0, 8'd10, 8'd0, 8'd2,  8'd2, 8'd15, 8'd1, 8'd0},
    '{8'd7,  8'd0, 8'd0,  8'd5, 8'd7,  8'd3, 8'd17, 8'd2, 8'd4},
    '{8'd1,  8'd0, 8'd9,  8'd4, 8'd1,  8'd0, 8'd20, 8'd2, 8'd4}
  };

  int checks = 0, fails = 0;
  int cyc = 0, low_cnt = 0;
  int cfg_first, cfg_srst, cfg_polls; bit cfg_link0;
  int nreq, nwr, addr_bad, gap_bad, gap_n, scan_exp, polls_seen, miss_cyc, lat;
  bit found, srst_wr, aneg_wr, pend, q_we;
  logic [4:0] q_phy, q_reg; logic [15:0] q_wd, w0, w1, rd;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // management slave model, answers three cycles after a request
  always @(negedge clk) begin
    cyc++;
    if (!phy_rst_n) low_cnt++;
    if (mdio_done) mdio_done = 1'b0;
    if (mdio_req) begin
      nreq++;
      q_we = mdio_we; q_phy = mdio_phy; q_reg = mdio_reg; q_wd = mdio_wdata;
      pend = 1'b1; lat = 2;
      if (miss_cyc >= 0) begin
        gap_n++;
        if (cyc - miss_cyc != G + 1) begin
          gap_bad++;
          $display("FAIL R8 actual=%0d expected=%0d", cyc - miss_cyc, G + 1);
        end
        miss_cyc = -1;
      end
      if (mdio_we) begin
        if (nwr == 0) w0 = mdio_wdata; else w1 = mdio_wdata;
        nwr++;
      end
      if (found && int'(mdio_phy) != cfg_first) addr_bad++;
      if (!found && !(mdio_reg == 5'd0 && !mdio_we && int'(mdio_phy) == scan_exp)) addr_bad++;
    end else if (pend) begin
      if (lat > 0) lat--;
      else begin
        pend = 1'b0;
        if (q_we) begin
          if (q_wd == 16'h8000) srst_wr = 1'b1;
          else if (q_wd == 16'h1300) aneg_wr = 1'b1;
          rd = 16'h0;
        end else if (int'(q_phy) != cfg_first) begin
          rd = 16'hFFFF;
          if (!found) scan_exp++;
        end else if (q_reg == 5'd0) begin
          if (!srst_wr) begin rd = 16'h3100; found = 1'b1; end
          else if (cfg_srst > 0) begin cfg_srst--; rd = 16'h8000; end
          else rd = 16'h1100;
        end else begin
          if (!aneg_wr) rd = cfg_link0 ? 16'h786D : 16'h7869;
          else if (polls_seen < cfg_polls) begin
            polls_seen++; rd = 16'h7869; miss_cyc = cyc + 1;
          end else rd = 16'h786D;
        end
        mdio_rdata = rd;
        mdio_done  = 1'b1;
      end
    end
  end

  task automatic run(input vec_t v, input bit mid, input string nm);
    bit got;
    cfg_first = int'(v.first); cfg_link0 = v.link0[0]; cfg_srst = int'(v.srst);
    cfg_polls = int'(v.polls);
    nreq = 0; nwr = 0; addr_bad = 0; gap_bad = 0; gap_n = 0; scan_exp = 0;
    polls_seen = 0; miss_cyc = -1; found = 0; srst_wr = 0; aneg_wr = 0; low_cnt = 0;
    w0 = 16'h0; w1 = 16'h0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!phy_rst_n, {nm, " R1 reset asserted"}, phy_rst_n, 0);
    chk({link_up, err_no_phy, err_soft_rst, warn_link_timeout} == 4'b0,
        {nm, " R11 flags cleared on start"},
        {link_up, err_no_phy, err_soft_rst, warn_link_timeout}, 0);
    got = 1'b0;
    for (int i = 0; i < 20000 && !got; i++) begin
      @(negedge clk);
      start = (mid && i == 40);
      if (done) got = 1'b1;
    end
    start = 1'b0;
    if (!got) begin
      chk(1'b0, {nm, " R11 watchdog no done"}, 0, 1);
    end else begin
      chk(int'(phy_addr) == int'(v.eaddr), {nm, " R2 phy_addr"}, phy_addr, v.eaddr);
      chk(link_up == (v.eres == 8'd0), {nm, " R4 R7 link_up"}, link_up, v.eres == 8'd0);
      chk(err_no_phy == (v.eres == 8'd1), {nm, " R3 err_no_phy"}, err_no_phy, v.eres == 8'd1);
      chk(err_soft_rst == (v.eres == 8'd2), {nm, " R6 err_soft_rst"}, err_soft_rst, v.eres == 8'd2);
      chk(warn_link_timeout == (v.eres == 8'd3), {nm, " R9 warn_link_timeout"},
          warn_link_timeout, v.eres == 8'd3);
      repeat (4) @(negedge clk);
      chk(!done, {nm, " R11 done one cycle"}, done, 0);
      chk(link_up == (v.eres == 8'd0) && err_no_phy == (v.eres == 8'd1) &&
          err_soft_rst == (v.eres == 8'd2) && warn_link_timeout == (v.eres == 8'd3),
          {nm, " R11 flags held"}, {link_up, err_no_phy, err_soft_rst, warn_link_timeout}, v.eres);
    end
    chk(nreq == int'(v.enreq), {nm, " R5 request count"}, nreq, v.enreq);
    chk(nwr == int'(v.enwr), {nm, " R4 R5 write count"}, nwr, v.enwr);
    if (v.enwr >= 8'd1) chk(w0 == 16'h8000, {nm, " R5 soft reset word"}, w0, 16'h8000);
    if (v.enwr >= 8'd2) chk(w1 == 16'h1300, {nm, " R7 autoneg word"}, w1, 16'h1300);
    chk(low_cnt == H, {nm, " R1 hold length"}, low_cnt, H);
    chk(addr_bad == 0, {nm, " R2 scan order and address"}, addr_bad, 0);
    chk(gap_bad == 0 && gap_n == int'(v.egaps), {nm, " R8 poll gaps"}, gap_n, v.egaps);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(phy_rst_n == 1'b1, "R12 reset phy_rst_n", phy_rst_n, 1);
    chk(!mdio_req && !done, "R12 reset req/done", {mdio_req, done}, 0);
    chk(phy_addr == 5'd0, "R12 reset phy_addr", phy_addr, 0);
    chk({link_up, err_no_phy, err_soft_rst, warn_link_timeout} == 4'b0, "R12 reset flags",
        {link_up, err_no_phy, err_soft_rst, warn_link_timeout}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(phy_rst_n == 1'b1 && !mdio_req, "R12 idle after reset", {phy_rst_n, mdio_req}, 2);
    for (int k = 0; k < NV; k++) run(VEC[k], 1'b0, $sformatf("vec%0d", k));
    // directed: start during a run is ignored (R11)
    run(VEC[2], 1'b1, "mid_start R11");
    // directed: back-to-back run clears previous error flags
    run(VEC[3], 1'b0, "again_nophy");
    run(VEC[0], 1'b0, "after_err");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 20);
    fails++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule